// File: doc/BRIEF.md
# Gated Echo Time-of-Flight Counter

This block turns the delay between a frame's start strobe and the arrival of an echo into a small binary number. A start strobe opens a counting window. Echo detection closes it, and a slow measurement tick is counted while the window is open. Once per frame the count is copied into a held output register. A valid strobe marks each copy. A later clear strobe then zeroes the running count for the next frame.

There are two echo-detect inputs. One is a near-echo input: while it is high, the window stays shut even if the start strobe fires. The other is a normal echo input, which closes the window when it rises. All inputs are synchronous levels in the single system clock domain. The block finds the edges it needs by comparing each input with a registered copy of itself. The result runs from 0 (nearest target) to the all-ones value (farthest or no echo). It does not wrap.

Top module: `echo_tof_counter`

## Requirements
- R1: A rising edge on `frame_start` opens the counting window from the next clock cycle. The window stays open after `frame_start` returns low, until it is closed.
- R2: A rising edge on `echo_far` closes the window from the next clock cycle. An `echo_far` input that stays high does not keep a window closed when a later `frame_start` edge opens it.
- R3: While `echo_near` is high, the window is closed from the next cycle. This holds whatever `frame_start` and `echo_far` do.
- R4: The running count rises by one for each clock cycle in which `tick` is high while the window is open. While `count_clr` is high, the count is zero from the next cycle, and the clear wins over a tick.
- R5: The running count saturates at 2^CNT_W-1 (63 at the default width). It never wraps to zero.
- R6: A rising edge on `capture` loads the running count into `distance`, visible in the next cycle. `distance` holds its value at every other time.
- R7: `valid` is high for exactly the one cycle after each `capture` rising edge, and low otherwise.
- R8: After a synchronous reset, `distance` is 0, `valid` is 0, the window is closed and the running count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| capture | input | 1 | Frame capture strobe; its rising edge latches the count |
| count_clr | input | 1 | Level clear of the running count |
| frame_start | input | 1 | Frame start strobe; its rising edge opens the window |
| tick | input | 1 | Measurement tick, counted while the window is open |
| echo_near | input | 1 | Near-echo detect; high holds the window closed |
| echo_far | input | 1 | Echo detect; its rising edge closes the window |
| distance | output | CNT_W | Latched echo delay count |
| valid | output | 1 | One-cycle strobe marking a new `distance` |

## Verification
The assertions assume every input is already synchronous to `clk` and stable across each rising edge. No synchronizer sits in front of the edge finders. The assertions also assume that a strobe level which is held counts as one edge. The bench drives every input on the falling edge of the clock, so all values are settled a half period before the design samples them. Frames keep the ordering the system relies on: start, ticks, echo, capture, and only then clear. A random segment deliberately breaks that ordering with free-running, overlapping strobes, and checks each cycle against a reference model.

// File: rtl/tof_pkg.sv
`timescale 1ns/1ps
package tof_pkg;

   typedef enum logic {
      WIN_SHUT = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   localparam int unsigned TOF_DEF_WIDTH = 6;

   // Next value of an up-counter that either stops at its ceiling or rolls over.
   function automatic logic [31:0] bump(input logic [31:0] cur,
                                        input logic [31:0] ceil,
                                        input bit          hold_at_ceil);
      if (cur == ceil)
         return hold_at_ceil ? ceil : 32'd0;
      return cur + 32'd1;
   endfunction

endpackage

// File: rtl/tof_edge.sv
`timescale 1ns/1ps
module tof_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= sig_i;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse_o = sig_i & ~prev_q;
      end else begin : g_fall
         assign pulse_o = ~sig_i & prev_q;
      end
   endgenerate

   // An edge pulse can never repeat on consecutive cycles (supports R7)
   p_edge_single_r7: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/tof_gate.sv
`timescale 1ns/1ps
module tof_gate
   import tof_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic open_i,
   input  logic shut_edge_i,
   input  logic shut_hold_i,
   output logic open_o
);
   win_state_e state_q, state_d;

   // Priority: hard hold > echo edge > start edge > keep.
   always_comb begin
      state_d = state_q;
      if (shut_hold_i)      state_d = WIN_SHUT;
      else if (shut_edge_i) state_d = WIN_SHUT;
      else if (open_i)      state_d = WIN_OPEN;
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= WIN_SHUT;
      else     state_q <= state_d;
   end

   assign open_o = (state_q == WIN_OPEN);

   p_open_r1: assert property (@(posedge clk) disable iff (rst)
      (open_i && !shut_edge_i && !shut_hold_i) |=> open_o);
   p_keep_r1: assert property (@(posedge clk) disable iff (rst)
      (!open_i && !shut_edge_i && !shut_hold_i) |=> $stable(open_o));
   p_echo_close_r2: assert property (@(posedge clk) disable iff (rst)
      shut_edge_i |=> !open_o);
   p_near_hold_r3: assert property (@(posedge clk) disable iff (rst)
      shut_hold_i |=> !open_o);

endmodule

// File: rtl/tof_counter.sv
`timescale 1ns/1ps
module tof_counter
   import tof_pkg::*;
#(
   parameter int unsigned CNT_W    = TOF_DEF_WIDTH,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [31:0]      nxt;

   assign nxt = bump(32'(cnt_q), 32'(CEIL), SATURATE);

   always_ff @(posedge clk) begin
      if (rst || clr_i) cnt_q <= '0;
      else if (inc_i)   cnt_q <= nxt[CNT_W-1:0];
   end

   assign cnt_o = cnt_q;

   p_clear_r4: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> cnt_q == '0);
   p_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (!clr_i && !inc_i) |=> $stable(cnt_q));
   p_step_r4: assert property (@(posedge clk) disable iff (rst)
      (!clr_i && inc_i && cnt_q != CEIL) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

   generate
      if (SATURATE) begin : g_sat
         p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
            (!clr_i && cnt_q == CEIL) |=> cnt_q == CEIL);
      end
   endgenerate

endmodule

// File: rtl/tof_capture.sv
`timescale 1ns/1ps
module tof_capture #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_i,
   input  logic [CNT_W-1:0] din_i,
   output logic [CNT_W-1:0] dist_o,
   output logic             valid_o
);
   logic [CNT_W-1:0] dist_q;
   logic             valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dist_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= cap_i;
         if (cap_i) dist_q <= din_i;
      end
   end

   assign dist_o  = dist_q;
   assign valid_o = valid_q;

   p_load_r6: assert property (@(posedge clk) disable iff (rst)
      cap_i |=> dist_q == $past(din_i));
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !cap_i |=> $stable(dist_q));
   p_strobe_r7: assert property (@(posedge clk) disable iff (rst)
      cap_i |=> valid_q);
   p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !cap_i |=> !valid_q);

endmodule

// File: rtl/echo_tof_counter.sv
`timescale 1ns/1ps
module echo_tof_counter
   import tof_pkg::*;
#(
   parameter int unsigned CNT_W    = TOF_DEF_WIDTH,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic             count_clr,
   input  logic             frame_start,
   input  logic             tick,
   input  logic             echo_near,
   input  logic             echo_far,
   output logic [CNT_W-1:0] distance,
   output logic             valid
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("echo_tof_counter: CNT_W must lie in 2..16");
      end
   endgenerate

   logic start_edge, cap_edge, echo_edge, win_open;
   logic [CNT_W-1:0] run_cnt;

   tof_edge #(.RISING(1'b1)) i_start_edge (
      .clk(clk), .rst(rst), .sig_i(frame_start), .pulse_o(start_edge));
   tof_edge #(.RISING(1'b1)) i_cap_edge (
      .clk(clk), .rst(rst), .sig_i(capture), .pulse_o(cap_edge));
   tof_edge #(.RISING(1'b1)) i_echo_edge (
      .clk(clk), .rst(rst), .sig_i(echo_far), .pulse_o(echo_edge));

   tof_gate i_gate (
      .clk(clk), .rst(rst),
      .open_i(start_edge), .shut_edge_i(echo_edge), .shut_hold_i(echo_near),
      .open_o(win_open));

   tof_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) i_counter (
      .clk(clk), .rst(rst),
      .inc_i(win_open & tick), .clr_i(count_clr),
      .cnt_o(run_cnt));

   tof_capture #(.CNT_W(CNT_W)) i_capture (
      .clk(clk), .rst(rst),
      .cap_i(cap_edge), .din_i(run_cnt),
      .dist_o(distance), .valid_o(valid));

   // Window shut means no tick can move the count (R3 through to R4)
   p_shut_no_count_r3: assert property (@(posedge clk) disable iff (rst)
      (echo_near && !count_clr) |=> ##1 (!count_clr && !$past(count_clr)) |-> run_cnt == $past(run_cnt));

endmodule

// File: tb/test_echo_tof_counter.sv
`timescale 1ns/1ps
module test_echo_tof_counter;
   localparam int W = 6;
   localparam int CEIL = (1 << W) - 1;

   logic clk = 1'b0, rst = 1'b1;
   logic capture = 0, count_clr = 0, frame_start = 0, tick = 0, echo_near = 0, echo_far = 0;
   logic [W-1:0] distance;
   logic valid;

   int errors = 0, checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   echo_tof_counter #(.CNT_W(W), .SATURATE(1'b1)) i_echo_tof_counter (
      .clk(clk), .rst(rst), .capture(capture), .count_clr(count_clr),
      .frame_start(frame_start), .tick(tick), .echo_near(echo_near),
      .echo_far(echo_far), .distance(distance), .valid(valid));

   // Reference model built from the requirements
   logic m_sq, m_cq, m_eq, m_open, m_valid;
   int   m_cnt, m_dist;

   always @(posedge clk) begin
      bit s_e, c_e, e_e, n_open;
      int n_cnt;
      if (rst) begin
         m_sq = 0; m_cq = 0; m_eq = 0; m_open = 0; m_valid = 0; m_cnt = 0; m_dist = 0;
      end else begin
         s_e = frame_start && !m_sq;
         c_e = capture && !m_cq;
         e_e = echo_far && !m_eq;
         n_open = echo_near ? 1'b0 : e_e ? 1'b0 : s_e ? 1'b1 : m_open;
         n_cnt  = count_clr ? 0 : (m_open && tick) ? (m_cnt < CEIL ? m_cnt + 1 : CEIL) : m_cnt;
         m_valid = c_e;
         if (c_e) m_dist = m_cnt;
         m_open = n_open; m_cnt = n_cnt;
         m_sq = frame_start; m_cq = capture; m_eq = echo_far;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle(bit t, bit dn, bit df, bit fs, bit cp, bit cc);
      @(negedge clk);
      if (!rst) begin
         chk("R6 distance vs model", int'(distance), m_dist);
         chk("R7 valid vs model", int'(valid), int'(m_valid));
      end
      tick = t; echo_near = dn; echo_far = df; frame_start = fs; capture = cp; count_clr = cc;
   endtask

   function automatic int exp_frame(int n_in, int n_after, bit near, bit far_hold);
      int n;
      if (near) return 0;
      n = far_hold ? n_in + n_after : n_in;
      return (n > CEIL) ? CEIL : n;
   endfunction

   task automatic frame(string tag, int n_in, int n_after, bit near, bit far_hold);
      int exp;
      exp = exp_frame(n_in, n_after, near, far_hold);
      repeat (2) cycle(0, near, far_hold, 0, 0, 0);
      repeat (3) cycle(0, near, far_hold, 1, 0, 0);
      repeat (2) cycle(0, near, far_hold, 0, 0, 0);
      for (int i = 0; i < n_in; i++) begin
         cycle(1, near, far_hold, 0, 0, 0);
         cycle(0, near, far_hold, 0, 0, 0);
      end
      if (!far_hold) begin
         cycle(0, near, 1, 0, 0, 0);
         cycle(0, near, 1, 0, 0, 0);
         cycle(0, near, 0, 0, 0, 0);
      end
      for (int i = 0; i < n_after; i++) begin
         cycle(1, near, far_hold, 0, 0, 0);
         cycle(0, near, far_hold, 0, 0, 0);
      end
      cycle(0, near, far_hold, 0, 1, 0);
      @(posedge clk); #1;
      chk(tag, int'(distance), exp);
      chk("R7 valid after capture", int'(valid), 1);
      cycle(0, near, far_hold, 0, 1, 1);
      cycle(0, near, far_hold, 0, 1, 1);
      cycle(0, near, far_hold, 0, 0, 0);
      cycle(0, near, far_hold, 0, 0, 0);
      chk("R6 distance held after clear", int'(distance), exp);
      chk("R7 valid single cycle", int'(valid), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R8 distance after reset", int'(distance), 0);
      chk("R8 valid after reset", int'(valid), 0);
      // R8: the window and the count start at zero, so a capture right away reads 0
      cycle(0, 0, 0, 0, 1, 0);
      @(posedge clk); #1;
      chk("R8 count zero after reset", int'(distance), 0);
      cycle(0, 0, 0, 0, 0, 0);

      frame("R1 R4 basic count of 10", 10, 5, 0, 0);
      frame("R2 echo edge stops count at 3", 3, 20, 0, 0);
      frame("R4 empty window gives 0", 0, 4, 0, 0);
      frame("R5 saturation at ceiling", 70, 0, 0, 0);
      frame("R5 exact ceiling 63", 63, 2, 0, 0);
      frame("R3 near echo blocks start", 12, 4, 1, 0);
      frame("R2 held echo_far does not block", 7, 6, 0, 1);

      for (int f = 0; f < 30; f++) begin
         int a, b;
         a = int'($urandom % 80);
         b = int'($urandom % 10);
         frame("R4 random frame", a, b, ($urandom % 6) == 0, ($urandom % 5) == 0);
      end

      // Free-running overlapping strobes, checked against the model
      for (int c = 0; c < 3000; c++) begin
         cycle(($urandom % 3) == 0, ($urandom % 16) == 0, ($urandom % 12) == 0,
               ($urandom % 10) == 0, ($urandom % 9) == 0, ($urandom % 20) == 0);
      end
      cycle(0, 0, 0, 0, 0, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule